// File: doc/BRIEF.md
# Bit-Serial-Stage Pipelined Adder

This block adds two unsigned operands in a pipeline that has one stage per bit. Each stage holds a single full adder, and a register between adjacent stages cuts the carry chain. The longest combinational path is therefore one full-adder delay, whatever the operand width. Because the carry reaches bit i only i cycles after the operation enters, operand bit i is held back by i cycles in a triangular skew store. Each sum bit is then held for the remaining cycles, so that all sum bits of one operation leave at the same time.

A new operand pair can be presented on every clock, qualified by a valid input. The matching result, with its carry-out, appears exactly WIDTH cycles later together with an output valid. There are no stalls and no back-pressure. The block only adds.

Top module: `bit_pipe_adder`

## Requirements
- R1: For an operation accepted at a clock edge with valid_i high, sum_o equals (a_i + b_i) mod 2^WIDTH in the cycle that follows the WIDTH-th edge counted from (and including) the accepting edge.
- R2: carry_o in that same cycle equals bit WIDTH of the full (WIDTH+1)-bit sum a_i + b_i, aligned with the sum bits of the same operation.
- R3: A new operation can be accepted on every clock edge, and back-to-back operations each produce their own correct result on consecutive cycles.
- R4: valid_o is high exactly WIDTH cycles after each edge at which valid_i was high, and low in every other cycle. Input cycles with valid_i low never produce a high valid_o, whatever a_i and b_i carry.
- R5: The active-low asynchronous reset rst_ni clears every valid, carry and data register. While reset is held, and for the first WIDTH edges after it is released, valid_o stays low and carry_o reads 0. A reset in the middle of traffic discards every operation in flight.
- R6: Each stage registers its carry-out before it reaches the next stage. The registered carry is 1 when both operand bits are 1, 0 when both are 0, and equals the incoming carry otherwise.
- R7: No carry leaks between operations: an operation that follows a full-width carry ripple (for example all-ones plus one) gets a result that depends only on its own operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand pair on a_i/b_i is to be added |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| valid_o | output | 1 | sum_o/carry_o hold an aligned result |
| sum_o | output | WIDTH | Sum bits of one operation |
| carry_o | output | 1 | Carry-out of the most significant stage |

## Verification
The bench builds the block with its default WIDTH of 32. At that width a single operand pair such as all-ones plus one sends a carry through all 32 registered stages and all 32 skew depths, from the shortest delay line to the longest. The directed cases cover full ripple, no carry at all, and carry out of the top bit only. Random traffic with gaps in valid_i fills the pipeline with up to 32 overlapping operations, so any misalignment between the skew, carry and deskew paths shows up as a wrong bit.

// File: rtl/bpa_pkg.sv
package bpa_pkg;

  typedef struct packed {
    logic carry;
    logic sum;
  } fa_out_t;

  function automatic fa_out_t fa_eval(input logic a, input logic b, input logic c);
    fa_out_t r;
    r.sum   = a ^ b ^ c;
    r.carry = (a & b) | (c & (a ^ b));
    return r;
  endfunction

endpackage

// File: rtl/bpa_delay_line.sv
module bpa_delay_line #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned DEPTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] tap_q [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_tap
    if (k == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tap_q[k] <= '0;
        else         tap_q[k] <= d_i;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tap_q[k] <= '0;
        else         tap_q[k] <= tap_q[k-1];
      end
    end
  end

  assign q_o = tap_q[DEPTH-1];

endmodule

// File: rtl/bpa_fa_stage.sv
module bpa_fa_stage
  import bpa_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic sum_q_o,
  output logic carry_q_o
);

  fa_out_t fa;

  assign fa = fa_eval(a_i, b_i, c_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q_o   <= 1'b0;
      carry_q_o <= 1'b0;
    end else begin
      sum_q_o   <= fa.sum;
      carry_q_o <= fa.carry;
    end
  end

  // R6: registered carry follows generate / kill / propagate
  p_carry_gen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_i && b_i) |=> carry_q_o);
  p_carry_kill_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!a_i && !b_i) |=> !carry_q_o);
  p_carry_prop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_i ^ b_i) |=> (carry_q_o == $past(c_i)));

endmodule

// File: rtl/bit_pipe_adder.sv
module bit_pipe_adder #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);

  localparam int unsigned CNT_W = $clog2(WIDTH + 1);

  logic [WIDTH:0]   carry_q;
  logic [WIDTH-1:0] a_skew;
  logic [WIDTH-1:0] b_skew;
  logic [WIDTH-1:0] sum_q;

  assign carry_q[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    // input skew: bit i waits i cycles for its carry
    if (i == 0) begin : g_no_skew
      assign a_skew[i] = a_i[i];
      assign b_skew[i] = b_i[i];
    end else begin : g_skew
      bpa_delay_line #(.WIDTH(2), .DEPTH(i)) u_skew (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    ({a_i[i], b_i[i]}),
        .q_o    ({a_skew[i], b_skew[i]})
      );
    end

    bpa_fa_stage u_stage (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .a_i       (a_skew[i]),
      .b_i       (b_skew[i]),
      .c_i       (carry_q[i]),
      .sum_q_o   (sum_q[i]),
      .carry_q_o (carry_q[i+1])
    );

    // output deskew: bit i waits for the top stage
    if (i == WIDTH - 1) begin : g_no_deskew
      assign sum_o[i] = sum_q[i];
    end else begin : g_deskew
      bpa_delay_line #(.WIDTH(1), .DEPTH(WIDTH - 1 - i)) u_deskew (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (sum_q[i]),
        .q_o    (sum_o[i])
      );
    end
  end

  bpa_delay_line #(.WIDTH(1), .DEPTH(WIDTH)) u_valid_line (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (valid_i),
    .q_o    (valid_o)
  );

  assign carry_o = carry_q[WIDTH];

  // edges since reset, saturating at WIDTH
  logic [CNT_W-1:0] warm_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          warm_cnt_q <= '0;
    else if (warm_cnt_q != CNT_W'(WIDTH)) warm_cnt_q <= warm_cnt_q + 1'b1;
  end

  // R5: nothing can emerge before the pipeline has filled
  p_no_early_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_cnt_q < CNT_W'(WIDTH)) |-> !valid_o);
  p_no_early_carry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_cnt_q < CNT_W'(WIDTH)) |-> !carry_o);

endmodule

// File: tb/bit_pipe_adder_tb.sv
module bit_pipe_adder_tb;

  localparam int W  = 32;
  localparam int RB = 128;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_in = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic         valid_out;
  logic [W-1:0] sum_out;
  logic         carry_out;

  logic [W-1:0] exp_sum [RB];
  logic         exp_c   [RB];
  logic         exp_v   [RB];

  int    edge_cnt = 0;
  int    tests = 0;
  int    fails = 0;
  string tag = "";
  bit    done = 1'b0;

  always #4 clk = ~clk;

  bit_pipe_adder #(.WIDTH(W)) u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .valid_i (valid_in),
    .a_i     (a_in),
    .b_i     (b_in),
    .valid_o (valid_out),
    .sum_o   (sum_out),
    .carry_o (carry_out)
  );

  function automatic logic [W:0] ref_add(input logic [W-1:0] a, input logic [W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  always @(posedge clk) if (rst_n) edge_cnt <= edge_cnt + 1;

  // compare outputs against the ring of expected results
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int idx;
      idx = edge_cnt % RB;
      tests++;
      if (valid_out !== exp_v[idx]) begin
        fails++;
        $display("FAIL R4 %s valid_o=%0b expected %0b (edge %0d)", tag, valid_out, exp_v[idx], edge_cnt);
      end
      if (exp_v[idx] === 1'b1) begin
        tests++;
        if (sum_out !== exp_sum[idx]) begin
          fails++;
          $display("FAIL R1 %s sum_o=%h expected %h", tag, sum_out, exp_sum[idx]);
        end
        tests++;
        if (carry_out !== exp_c[idx]) begin
          fails++;
          $display("FAIL R2 %s carry_o=%0b expected %0b", tag, carry_out, exp_c[idx]);
        end
      end
      exp_v[idx] = 1'b0;
    end
  end

  task automatic drive(input logic v, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] r;
    int idx;
    @(negedge clk);
    valid_in = v;
    a_in     = a;
    b_in     = b;
    idx = (edge_cnt + W) % RB;
    r = ref_add(a, b);
    exp_v[idx]   = v;
    exp_sum[idx] = r[W-1:0];
    exp_c[idx]   = r[W];
  endtask

  task automatic check_cleared(input string what);
    tests++;
    if (valid_out !== 1'b0 || carry_out !== 1'b0) begin
      fails++;
      $display("FAIL R5 %s valid_o=%0b carry_o=%0b expected 0 0", what, valid_out, carry_out);
    end
  endtask

  task automatic clear_ring();
    for (int k = 0; k < RB; k++) begin
      exp_v[k]   = 1'b0;
      exp_sum[k] = '0;
      exp_c[k]   = 1'b0;
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0A11));
    clear_ring();
    repeat (3) @(negedge clk);
    check_cleared("R5 during reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R5: pipeline empty after reset, with junk on the data inputs
    tag = "[R5 fill]";
    for (int k = 0; k < W + 2; k++) drive(1'b0, W'($urandom), W'($urandom));

    // R1 R2: directed corners
    tag = "[R1 R2 corners]";
    drive(1'b1, '0, '0);
    drive(1'b1, '1, W'(1));                  // full ripple through every stage
    drive(1'b1, '1, '1);
    drive(1'b1, {1'b1, {(W-1){1'b0}}}, {1'b1, {(W-1){1'b0}}});
    drive(1'b1, {(W/2){2'b10}}, {(W/2){2'b01}});
    drive(1'b1, W'(1), '1);
    // R7: operation right after a full ripple sees no stale carry
    tag = "[R7 no leak]";
    drive(1'b1, '1, W'(1));
    drive(1'b1, '0, '0);
    drive(1'b1, '1, '0);
    drive(1'b0, '1, '1);                     // R4: ignored input
    drive(1'b1, W'(3), W'(5));
    for (int k = 0; k < W + 2; k++) drive(1'b0, '1, '1);

    // R3: back-to-back random operations
    tag = "[R3 back-to-back]";
    for (int k = 0; k < 300; k++) drive(1'b1, W'($urandom), W'($urandom));

    // R4: random gaps in valid_i
    tag = "[R4 gaps]";
    for (int k = 0; k < 1200; k++)
      drive(($urandom % 4) != 0, W'($urandom), W'($urandom));

    // R5: reset with operations in flight discards them
    tag = "[R5 mid reset]";
    for (int k = 0; k < W / 2; k++) drive(1'b1, '1, W'($urandom));
    @(negedge clk);
    rst_n = 1'b0;
    valid_in = 1'b0;
    clear_ring();
    @(negedge clk);
    check_cleared("R5 mid reset");
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < W + 2; k++) drive(1'b0, W'($urandom), W'($urandom));
    tag = "[R1 after reset]";
    drive(1'b1, '1, '1);
    drive(1'b1, W'(7), W'(9));
    for (int k = 0; k < W + 4; k++) drive(1'b0, '0, '0);

    finish_run();
  end

endmodule